// File: doc/BRIEF.md
# Host Byte Mailbox Port

This block is the device-side model of a narrow host I/O window. The host addresses it with byte reads and writes. Through it the host exchanges single bytes with an on-board controller. Each direction has a one-byte holding register. A receive holder takes bytes from the board over a valid/ready interface and keeps each byte until the host reads it. A transmit holder takes a byte from the host and offers it to the board over a second valid/ready interface. The host polls two status offsets to learn whether a received byte is waiting and whether the transmit holder can accept a byte.

The two status offsets do different jobs for reads and for writes. A read returns a flag. A write sets or clears the interrupt enable. The interrupt line is high while it is enabled and a received byte waits. A further offset holds a reset control. Writing 1 and then 0 to it takes the board through a low, high, low reset sequence. A phase state machine tracks that sequence, with these states:
- PH_OFF: never pulsed since reset.
- PH_HOLD: board held in reset.
- PH_UP: released after a pulse.

Writing 1 moves PH_OFF to PH_HOLD and PH_UP to PH_HOLD. Writing 0 moves PH_HOLD to PH_UP. Writing a value with any of bits 7..1 set does not touch the reset phase. Instead, such a value loads an interrupt routing field.

Each holder is a two-state machine with the states HOLD_EMPTY and HOLD_FULL. A load moves HOLD_EMPTY to HOLD_FULL, and an unload moves HOLD_FULL to HOLD_EMPTY. A load that arrives while the holder is full is ignored. An unload that arrives while the holder is empty is also ignored.

Top module: `hostbox_port`

## Requirements
- R1: After reset:
  - reading offset 0x02 returns 0x00, and reading offset 0x03 returns 0x01;
  - reading offset 0x04 returns 0x00;
  - `irq`, `board_rst` and `brd_up` are 0, and `irq_route` is 0x0.
- R2: When the board side completes a valid/ready handshake, bit 0 of the offset 0x02 read becomes 1. `brd_rx_ready` stays 0 while that byte waits.
- R3: A host read of offset 0x00 while a byte waits returns that byte. The same read returns bit 0 of offset 0x02 to 0.
- R4: A host read of offset 0x00 while no byte waits returns 0x00 and changes no state.
- R5: A host write to offset 0x01 while the transmit holder is empty loads the byte, and the bytes reach the board in write order. Bit 0 of offset 0x03 reads 0 until the board takes the byte, and reads 1 after that.
- R6: A host write to offset 0x01 while the transmit holder is full is dropped. The byte already held stays on `brd_tx_data`.
- R7: A host write to offset 0x02 or 0x03 sets the interrupt enable to bit 1 of the written value: 0x02 enables and 0x00 disables. `irq` is 1 exactly when the enable is set and a received byte waits.
- R8: Offset 0x04 reads back the last byte the host wrote to any offset.
- R9: Offset 0x05 reads back the REVISION parameter.
- R10: A host write of 0x01 to offset 0x10 raises `board_rst`. A following write of 0x00 lowers `board_rst` and raises `brd_up`. `board_rst` and `brd_up` are never high together.
- R11: A host write to offset 0x10 of a value with any of bits 7..1 set loads bits 7..4 into `irq_route` (so 0xF0 selects route 0xF). Such a write leaves `board_rst` and `brd_up` unchanged.
- R12: A host read of an unmapped offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_sel | input | 1 | Host access strobe, one cycle per access |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_addr | input | 5 | Byte offset |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Host read data, valid in the strobe cycle |
| brd_rx_valid | input | 1 | Board offers a byte to the host |
| brd_rx_data | input | 8 | Byte from the board |
| brd_rx_ready | output | 1 | Receive holder empty |
| brd_tx_valid | output | 1 | Transmit holder has a byte for the board |
| brd_tx_data | output | 8 | Byte to the board |
| brd_tx_ready | input | 1 | Board takes the byte |
| irq | output | 1 | Interrupt request |
| board_rst | output | 1 | Board reset, high in phase PH_HOLD |
| brd_up | output | 1 | Board released after a pulse (PH_UP) |
| irq_route | output | 4 | Interrupt routing selection |

## Verification
The transmit path is tried with three patterns:
- a single byte while the board is stalled, followed by a second write, which tells a dropped write (R6) apart from an overwrite;
- a burst against a ready board, which shows ordering through a scoreboard queue;
- an empty-holder check after the drain.

The receive path is tried with two patterns:
- a read of offset 0x00 while nothing waits, which tells a side-effect-free read (R4) apart from a clear;
- a real byte, whose read must both return the byte and clear the flag.

The interrupt enable is toggled through both status offsets while a byte waits, so that the enable is seen apart from the flag. The reset control is driven with the values 1, 0 and 0xF0, which separates the reset phases from a write to the routing field.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
    localparam int OFS_RXDATA  = 'h00;
    localparam int OFS_TXDATA  = 'h01;
    localparam int OFS_INSTAT  = 'h02;
    localparam int OFS_OUTSTAT = 'h03;
    localparam int OFS_ECHO    = 'h04;
    localparam int OFS_REV     = 'h05;
    localparam int OFS_RSTCTL  = 'h10;

    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_t;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HOLD = 2'd1,
        PH_UP   = 2'd2
    } rst_phase_t;
endpackage

// File: rtl/hbx_hold.sv
module hbx_hold
    import hbx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          unload,
    output logic          full,
    output logic [DW-1:0] data
);
    hold_state_t   state_q, state_d;
    logic [DW-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_EMPTY: if (load)   state_d = HOLD_FULL;
            HOLD_FULL:  if (unload) state_d = HOLD_EMPTY;
            default:                state_d = HOLD_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOLD_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == HOLD_EMPTY && load)
                data_q <= ld_data;
        end
    end

    always_comb begin
        full = (state_q == HOLD_FULL);
        data = data_q;
    end
endmodule

// File: rtl/hbx_rst_seq.sv
module hbx_rst_seq
    import hbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic hold,
    output logic up
);
    rst_phase_t ph_q, ph_d;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_OFF:  if (wr_en && wr_bit)  ph_d = PH_HOLD;
            PH_HOLD: if (wr_en && !wr_bit) ph_d = PH_UP;
            PH_UP:   if (wr_en && wr_bit)  ph_d = PH_HOLD;
            default:                       ph_d = PH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_OFF;
        else        ph_q <= ph_d;
    end

    always_comb begin
        hold = (ph_q == PH_HOLD);
        up   = (ph_q == PH_UP);
    end
endmodule

// File: rtl/hostbox_port.sv
module hostbox_port
    import hbx_pkg::*;
#(
    parameter int          AW       = 5,
    parameter int          DW       = 8,
    parameter int          RW       = 4,
    parameter logic [7:0]  REVISION = 8'h5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hb_sel,
    input  logic          hb_wr,
    input  logic [AW-1:0] hb_addr,
    input  logic [DW-1:0] hb_wdata,
    output logic [DW-1:0] hb_rdata,
    input  logic          brd_rx_valid,
    input  logic [DW-1:0] brd_rx_data,
    output logic          brd_rx_ready,
    output logic          brd_tx_valid,
    output logic [DW-1:0] brd_tx_data,
    input  logic          brd_tx_ready,
    output logic          irq,
    output logic          board_rst,
    output logic          brd_up,
    output logic [RW-1:0] irq_route
);
    localparam int ENB_BIT = 1;

    logic          host_rd, host_wr;
    logic          rx_full, tx_full;
    logic [DW-1:0] rx_byte, tx_byte;
    logic          ien_q;
    logic [DW-1:0] echo_q;
    logic [RW-1:0] route_q;
    logic          rst_val_wr, route_wr;

    always_comb begin
        host_rd    = hb_sel && !hb_wr;
        host_wr    = hb_sel && hb_wr;
        rst_val_wr = host_wr && int'(hb_addr) == OFS_RSTCTL && hb_wdata[DW-1:1] == '0;
        route_wr   = host_wr && int'(hb_addr) == OFS_RSTCTL && hb_wdata[DW-1:1] != '0;
    end

    hbx_hold #(.DW(DW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (brd_rx_valid),
        .ld_data (brd_rx_data),
        .unload  (host_rd && int'(hb_addr) == OFS_RXDATA),
        .full    (rx_full),
        .data    (rx_byte)
    );

    hbx_hold #(.DW(DW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (host_wr && int'(hb_addr) == OFS_TXDATA),
        .ld_data (hb_wdata),
        .unload  (brd_tx_ready),
        .full    (tx_full),
        .data    (tx_byte)
    );

    hbx_rst_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rst_val_wr),
        .wr_bit (hb_wdata[0]),
        .hold   (board_rst),
        .up     (brd_up)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q   <= 1'b0;
            echo_q  <= '0;
            route_q <= '0;
        end else begin
            if (host_wr)
                echo_q <= hb_wdata;
            if (host_wr && (int'(hb_addr) == OFS_INSTAT || int'(hb_addr) == OFS_OUTSTAT))
                ien_q <= hb_wdata[ENB_BIT];
            if (route_wr)
                route_q <= hb_wdata[DW-1:DW-RW];
        end
    end

    always_comb begin
        hb_rdata = '0;
        if (host_rd) begin
            case (int'(hb_addr))
                OFS_RXDATA:  hb_rdata = rx_full ? rx_byte : '0;
                OFS_INSTAT:  hb_rdata = DW'(rx_full);
                OFS_OUTSTAT: hb_rdata = DW'(!tx_full);
                OFS_ECHO:    hb_rdata = echo_q;
                OFS_REV:     hb_rdata = DW'(REVISION);
                default:     hb_rdata = '0;
            endcase
        end
    end

    always_comb begin
        brd_rx_ready = !rx_full;
        brd_tx_valid = tx_full;
        brd_tx_data  = tx_byte;
        irq          = ien_q && rx_full;
        irq_route    = route_q;
    end
endmodule

// File: rtl/hbx_checker.sv
module hbx_checker #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hb_sel,
    input logic          hb_wr,
    input logic [AW-1:0] hb_addr,
    input logic [DW-1:0] hb_wdata,
    input logic [DW-1:0] hb_rdata,
    input logic          brd_rx_valid,
    input logic          brd_rx_ready,
    input logic          brd_tx_valid,
    input logic [DW-1:0] brd_tx_data,
    input logic          brd_tx_ready,
    input logic          irq,
    input logic          board_rst,
    input logic          brd_up
);
    p_rx_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_rx_valid && brd_rx_ready) |=> !brd_rx_ready);

    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_sel && !hb_wr && hb_addr == '0 && brd_rx_ready) |-> hb_rdata == '0);

    p_tx_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_sel && hb_wr && hb_addr == AW'(1) && !brd_tx_valid)
        |=> (brd_tx_valid && brd_tx_data == $past(hb_wdata)));

    p_tx_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_tx_valid && !brd_tx_ready) |=> (brd_tx_valid && $stable(brd_tx_data)));

    p_irq_needs_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !brd_rx_ready);

    p_phase_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(board_rst && brd_up));
endmodule

bind hostbox_port hbx_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hb_sel       (hb_sel),
    .hb_wr        (hb_wr),
    .hb_addr      (hb_addr),
    .hb_wdata     (hb_wdata),
    .hb_rdata     (hb_rdata),
    .brd_rx_valid (brd_rx_valid),
    .brd_rx_ready (brd_rx_ready),
    .brd_tx_valid (brd_tx_valid),
    .brd_tx_data  (brd_tx_data),
    .brd_tx_ready (brd_tx_ready),
    .irq          (irq),
    .board_rst    (board_rst),
    .brd_up       (brd_up)
);

// File: tb/tb_hostbox_port.sv
module tb_hostbox_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] REV = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hb_sel = 1'b0, hb_wr = 1'b0;
    logic [4:0] hb_addr = '0;
    logic [7:0] hb_wdata = '0, hb_rdata;
    logic       brd_rx_valid = 1'b0;
    logic [7:0] brd_rx_data = '0;
    logic       brd_rx_ready, brd_tx_valid, brd_tx_ready;
    logic [7:0] brd_tx_data;
    logic       irq, board_rst, brd_up;
    logic [3:0] irq_route;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbox_port #(.REVISION(REV)) dut (
        .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr),
        .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .brd_rx_valid(brd_rx_valid), .brd_rx_data(brd_rx_data),
        .brd_rx_ready(brd_rx_ready), .brd_tx_valid(brd_tx_valid),
        .brd_tx_data(brd_tx_data), .brd_tx_ready(brd_tx_ready),
        .irq(irq), .board_rst(board_rst), .brd_up(brd_up),
        .irq_route(irq_route)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic host_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        hb_sel = 1'b1; hb_wr = 1'b0; hb_addr = a;
        #1 d = hb_rdata;
        @(negedge clk);
        hb_sel = 1'b0;
    endtask

    task automatic host_write(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        hb_sel = 1'b1; hb_wr = 1'b1; hb_addr = a; hb_wdata = v;
        @(negedge clk);
        hb_sel = 1'b0; hb_wr = 1'b0;
    endtask

    task automatic board_send(input logic [7:0] b);
        @(negedge clk);
        brd_rx_valid = 1'b1; brd_rx_data = b;
        @(negedge clk);
        brd_rx_valid = 1'b0;
    endtask

    // Scoreboard monitor: every byte the board takes must be the next one queued (R5)
    always @(negedge clk) begin
        if (rst_n && brd_tx_valid && brd_tx_ready) begin
            if (exp_q.size() == 0) chk("R5 unexpected tx byte", brd_tx_data, 8'hxx);
            else chk("R5 tx order", brd_tx_data, exp_q.pop_front());
        end
    end

    initial begin
        brd_tx_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        host_read(5'h02, rd); chk("R1 instat", rd, 8'h00);
        host_read(5'h03, rd); chk("R1 outstat", rd, 8'h01);
        host_read(5'h04, rd); chk("R1 echo", rd, 8'h00);
        chk("R1 irq/rst/up", {5'd0, irq, board_rst, brd_up}, 8'h00);
        chk("R1 route", {4'd0, irq_route}, 8'h00);

        host_read(5'h05, rd); chk("R9 revision", rd, REV);
        host_read(5'h07, rd); chk("R12 unmapped", rd, 8'h00);

        host_read(5'h00, rd); chk("R4 empty read", rd, 8'h00);
        host_read(5'h02, rd); chk("R4 no state change", rd, 8'h00);

        board_send(8'h3C);
        host_read(5'h02, rd); chk("R2 instat full", rd, 8'h01);
        chk("R2 rx_ready low", {7'd0, brd_rx_ready}, 8'h00);

        chk("R7 irq disabled", {7'd0, irq}, 8'h00);
        host_write(5'h02, 8'h02); chk("R7 irq enabled", {7'd0, irq}, 8'h01);
        host_write(5'h02, 8'h00); chk("R7 irq off", {7'd0, irq}, 8'h00);
        host_write(5'h03, 8'h02); chk("R7 enable via 0x03", {7'd0, irq}, 8'h01);

        host_read(5'h00, rd); chk("R3 read byte", rd, 8'h3C);
        host_read(5'h02, rd); chk("R3 flag cleared", rd, 8'h00);
        chk("R7 irq drops with flag", {7'd0, irq}, 8'h00);

        exp_q.push_back(8'hA5);
        host_write(5'h01, 8'hA5);
        host_read(5'h03, rd); chk("R5 outstat busy", rd, 8'h00);
        host_write(5'h01, 8'h11);
        chk("R6 held byte kept", brd_tx_data, 8'hA5);
        host_read(5'h04, rd); chk("R8 echo last write", rd, 8'h11);
        brd_tx_ready = 1'b1;
        repeat (2) @(negedge clk);
        host_read(5'h03, rd); chk("R5 outstat free", rd, 8'h01);

        exp_q.push_back(8'h5A); host_write(5'h01, 8'h5A);
        exp_q.push_back(8'hC3); host_write(5'h01, 8'hC3);
        exp_q.push_back(8'h07); host_write(5'h01, 8'h07);
        repeat (3) @(negedge clk);
        chk("R5 queue drained", 8'(exp_q.size()), 8'h00);

        host_write(5'h10, 8'h01);
        chk("R10 held", {6'd0, board_rst, brd_up}, 8'h02);
        host_write(5'h10, 8'h00);
        chk("R10 released", {6'd0, board_rst, brd_up}, 8'h01);
        host_write(5'h10, 8'hF0);
        chk("R11 route", {4'd0, irq_route}, 8'h0F);
        chk("R11 phase kept", {6'd0, board_rst, brd_up}, 8'h01);
        host_read(5'h04, rd); chk("R8 echo reset write", rd, 8'hF0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule